// File: doc/BRIEF.md
# Bus Cycle Time Counter

This block keeps a 32-bit mixed-radix time register of the kind a serial bus uses to timestamp its isochronous cycles. The register holds three fields. The lowest is a sub-cycle offset that advances once per 24.576 MHz tick and runs 0 to 3071. The middle field is a cycle count that runs 0 to 7999, so each of its steps is 125 us. The top field is a seconds count that runs 0 to 127. When a field passes its last value it returns to zero and carries one into the field above. The seconds field wraps to zero silently, with no carry out.

The core runs from a faster system clock. A clock-enable input marks each 24.576 MHz tick. A synchronous load replaces the whole register in one edge, so a node can follow the time carried in a received cycle-start packet. If any field of the loaded value is beyond its range, that field is stored as zero. A registered pulse marks each new bus cycle, that is, each tick on which the offset wraps.

Top module: `cycle_timer`

## Requirements
- R1: After reset, `cycle_time` reads 0 and `cycle_start` is low.
- R2: The field positions in `cycle_time` and `load_val` are fixed: bits 31:25 hold seconds, bits 24:12 hold the cycle count, and bits 11:0 hold the offset.
- R3: On each clock with `tick_en` high and `load_en` low, the offset rises by one. With both `tick_en` and `load_en` low, `cycle_time` does not change.
- R4: A tick with the offset at 3071 sets the offset to 0 and raises the cycle count by one.
- R5: A tick with the offset at 3071 and the cycle count at 7999 sets both to 0 and raises seconds by one.
- R6: A tick with every field at its maximum (127, 7999, 3071) makes `cycle_time` 0, with no other effect.
- R7: With `load_en` high, `cycle_time` takes the value of `load_val` on that edge, whatever the value of `tick_en`.
- R8: On load, a cycle count field of 8000 or more, or an offset field of 3072 or more, is stored as 0. The other fields still load.
- R9: `cycle_start` is high for exactly the one clock after an edge on which the offset wrapped from 3071 to 0 through a tick. A load never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| tick_en | input | 1 | One-clock enable marking each 24.576 MHz tick |
| load_en | input | 1 | Replace the register with `load_val` on this edge |
| load_val | input | 32 | Time value to load, in the same field layout as `cycle_time` |
| cycle_time | output | 32 | Current time register |
| cycle_start | output | 1 | One-clock pulse following each offset wrap |

## Verification
Directed loads place the register just below each wrap point. This shows apart a plain offset step, a carry into the cycle count, a double carry into seconds, and the silent full wrap to zero. Loads that coincide with a tick, and loads with fields out of range, test load priority and the sanitising of each field separately. A long random run mixes sparse ticks, idle clocks and occasional loads. It compares every clock against a bench model, so a wrong hold, a missing carry or a stray or late cycle-start pulse all show up.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int unsigned OFS_W   = 12;
  localparam int unsigned OFS_LIM = 3072;
  localparam int unsigned CYC_W   = 13;
  localparam int unsigned CYC_LIM = 8000;
  localparam int unsigned SEC_W   = 7;
  localparam int unsigned SEC_LIM = 128;
  localparam int unsigned TIME_W  = OFS_W + CYC_W + SEC_W;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CYC_W-1:0] cyc;
    logic [OFS_W-1:0] ofs;
  } bus_time_t;
endpackage

// File: rtl/ctc_rst_sync.sv
module ctc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ctc_field.sv
module ctc_field #(
  parameter int unsigned W     = 12,
  parameter int unsigned LIMIT = 3072
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         wrap_o
);
  localparam int unsigned  LAST_I = LIMIT - 1;
  localparam logic [W-1:0] LAST   = LAST_I[W-1:0];

  logic [W-1:0] val_q, val_d, ld_clean;

  generate
    if (LIMIT < (2 ** W)) begin : g_clip
      assign ld_clean = (ld_val <= LAST) ? ld_val : '0;
      always @(posedge clk) begin
        if (rst_n) begin
          assert_field_range_R8 : assert (val_q <= LAST)
            else $error("field value %0d beyond limit %0d", val_q, LIMIT);
        end
      end
    end else begin : g_full
      assign ld_clean = ld_val;
    end
  endgenerate

  assign wrap_o = inc && (val_q == LAST);

  always_comb begin
    val_d = val_q;
    if (ld) begin
      val_d = ld_clean;
    end else if (inc) begin
      if (val_q == LAST) val_d = '0;
      else               val_d = val_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val = val_q;

  assert_field_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(val_q));
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import ctc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              load_en,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] cycle_time,
  output logic              cycle_start
);
  localparam int unsigned N_FIELDS = 3;

  logic      rst_n_i;
  bus_time_t cur, ld_t;
  logic [N_FIELDS-1:0] carry;
  logic      start_q, start_d;

  ctc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign ld_t = bus_time_t'(load_val);

  ctc_field #(.W(OFS_W), .LIMIT(OFS_LIM)) u_ofs (
    .clk(clk), .rst_n(rst_n_i), .inc(tick_en), .ld(load_en),
    .ld_val(ld_t.ofs), .val(cur.ofs), .wrap_o(carry[0])
  );

  ctc_field #(.W(CYC_W), .LIMIT(CYC_LIM)) u_cyc (
    .clk(clk), .rst_n(rst_n_i), .inc(carry[0]), .ld(load_en),
    .ld_val(ld_t.cyc), .val(cur.cyc), .wrap_o(carry[1])
  );

  ctc_field #(.W(SEC_W), .LIMIT(SEC_LIM)) u_sec (
    .clk(clk), .rst_n(rst_n_i), .inc(carry[1]), .ld(load_en),
    .ld_val(ld_t.sec), .val(cur.sec), .wrap_o(carry[2])
  );

  always_comb begin
    start_d = carry[0] && !load_en;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) start_q <= 1'b0;
    else          start_q <= start_d;
  end

  assign cycle_time  = cur;
  assign cycle_start = start_q;

  // R4: offset wrap carries one into the cycle count
  assert_cycle_carry_R4 : assert property (@(posedge clk) disable iff (!rst_n_i)
    (tick_en && !load_en && cur.ofs == OFS_W'(OFS_LIM-1) && cur.cyc != CYC_W'(CYC_LIM-1))
    |=> (cur.cyc == $past(cur.cyc) + 1'b1) && (cur.ofs == '0));

  // R6: full wrap lands on zero
  assert_full_wrap_R6 : assert property (@(posedge clk) disable iff (!rst_n_i)
    (tick_en && !load_en && cur.sec == SEC_W'(SEC_LIM-1) &&
     cur.cyc == CYC_W'(CYC_LIM-1) && cur.ofs == OFS_W'(OFS_LIM-1))
    |=> (cycle_time == '0));

  // R7: an in-range load wins over the tick
  assert_load_wins_R7 : assert property (@(posedge clk) disable iff (!rst_n_i)
    (load_en && ld_t.cyc < CYC_W'(CYC_LIM) && ld_t.ofs < OFS_W'(OFS_LIM))
    |=> (cycle_time == $past(load_val)));

  // R9: the pulse only follows a wrap to offset zero
  assert_start_zero_R9 : assert property (@(posedge clk) disable iff (!rst_n_i)
    cycle_start |-> (cur.ofs == '0) && !$past(load_en));
endmodule

// File: tb/cycle_timer_tb_top.sv
module cycle_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        load_en;
  logic [31:0] load_val;
  logic [31:0] cycle_time;
  logic        cycle_start;

  int unsigned n_checks;
  int unsigned n_fails;
  bit          done;
  logic [31:0] exp_t;
  logic        exp_p;

  cycle_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
    .load_val(load_val), .cycle_time(cycle_time), .cycle_start(cycle_start)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] pack_t(input int unsigned s, input int unsigned c,
                                         input int unsigned o);
    logic [31:0] r;
    r[31:25] = s[6:0];
    r[24:12] = c[12:0];
    r[11:0]  = o[11:0];
    return r;
  endfunction

  function automatic logic [31:0] model_next(input logic [31:0] t, input bit tk,
                                             input bit ld, input logic [31:0] v);
    int unsigned s, c, o;
    if (ld) begin
      s = v[31:25];
      c = (v[24:12] >= 13'd8000) ? 0 : v[24:12];
      o = (v[11:0]  >= 12'd3072) ? 0 : v[11:0];
    end else begin
      s = t[31:25]; c = t[24:12]; o = t[11:0];
      if (tk) begin
        if (o == 3071) begin
          o = 0;
          if (c == 7999) begin
            c = 0;
            s = (s == 127) ? 0 : s + 1;
          end else c = c + 1;
        end else o = o + 1;
      end
    end
    return pack_t(s, c, o);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit ld, input logic [31:0] v, input string tag);
    tick_en  = tk;
    load_en  = ld;
    load_val = v;
    @(posedge clk);
    exp_p = !ld && tk && (exp_t[11:0] == 12'd3071);
    exp_t = model_next(exp_t, tk, ld, v);
    #1;
    check(tag, cycle_time, exp_t);
    check({tag, " R9 pulse"}, {31'd0, cycle_start}, {31'd0, exp_p});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    tick_en = 1'b0; load_en = 1'b0; load_val = '0;
    exp_t = '0; exp_p = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset time", cycle_time, 32'd0);
    check("R1 reset pulse", {31'd0, cycle_start}, 32'd0);

    // R3: steps and holds
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, '0, "R3 step");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, "R3 hold");
    check("R3 offset five", cycle_time, 32'd5);

    // R2: field positions
    step(1'b0, 1'b1, pack_t(5, 100, 3070), "R2 load");
    check("R2 seconds bits", {25'd0, cycle_time[31:25]}, 32'd5);
    check("R2 cycle bits", {19'd0, cycle_time[24:12]}, 32'd100);
    check("R2 offset bits", {20'd0, cycle_time[11:0]}, 32'd3070);

    // R4: carry into the cycle count
    step(1'b1, 1'b0, '0, "R4 pre");
    step(1'b1, 1'b0, '0, "R4 carry");
    check("R4 value", cycle_time, pack_t(5, 101, 0));
    step(1'b0, 1'b0, '0, "R9 pulse ends");

    // R5: double carry
    step(1'b0, 1'b1, pack_t(3, 7999, 3071), "R5 load");
    step(1'b1, 1'b0, '0, "R5 carry");
    check("R5 value", cycle_time, pack_t(4, 0, 0));

    // R6: full wrap
    step(1'b0, 1'b1, pack_t(127, 7999, 3071), "R6 load");
    step(1'b1, 1'b0, '0, "R6 wrap");
    check("R6 value", cycle_time, 32'd0);

    // R7: load with tick at the wrap point, no pulse
    step(1'b0, 1'b1, pack_t(9, 20, 3071), "R7 setup");
    step(1'b1, 1'b1, pack_t(1, 2, 3), "R7 load wins");
    check("R7 value", cycle_time, pack_t(1, 2, 3));

    // R8: out-of-range fields
    step(1'b0, 1'b1, pack_t(7, 8191, 4000), "R8 both out");
    check("R8 both", cycle_time, pack_t(7, 0, 0));
    step(1'b0, 1'b1, pack_t(2, 8000, 3071), "R8 cycle out");
    check("R8 cycle", cycle_time, pack_t(2, 0, 3071));
    step(1'b1, 1'b1, pack_t(2, 7999, 3072), "R8 offset out");
    check("R8 offset", cycle_time, pack_t(2, 7999, 0));

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      logic [31:0] v;
      bit tk, ld;
      int unsigned r;
      r  = $urandom_range(0, 99);
      tk = (r < 70);
      ld = ($urandom_range(0, 199) == 0);
      r  = $urandom_range(0, 3);
      if (r == 0) v = $urandom;
      else v = pack_t($urandom_range(0, 127), 7990 + $urandom_range(0, 9),
                      3060 + $urandom_range(0, 11));
      step(tk, ld, v, ld ? "R7 random load" : (tk ? "R4 random tick" : "R3 random hold"));
    end

    finish_run();
  end
endmodule